// File: doc/BRIEF.md
# Channelized serial receive demultiplexer

This block sits behind a framed serial receive line. The line carries one data bit per clock, grouped into 8 kHz frames of eight-bit time slots. A sync pulse anchors the position inside the frame. For every received bit that falls in an enabled slot, a descriptor table decides which of 32 logical channels gets the bit. The block then emits the bit together with its channel number and a one-cycle valid strobe.

Four frame geometries are selectable:

| Mode | Code | Frame length | Slots |
|------|------|--------------|-------|
| T1 | 0 | 193 bits | 24 slots, after one framing bit |
| single E1 | 1 | 256 bits | 32 slots |
| double E1 | 2 | 512 bits | 64 slots |
| quadruple E1 | 3 | 1024 bits | 128 slots |

A slot can be given whole to one channel. Several slots, contiguous or scattered, may then form one wide channel. A slot can instead be split so that each of its eight bits is enabled and steered on its own. An out-of-frame input halts delivery until the line is aligned again by a sync pulse.

The table is loaded through a plain write port and is meant to be rewritten between frames. A downstream channel engine consumes the output stream.

Top module: `chan_rx_demux`

## Requirements
- R1: After reset, and until a sync pulse is sampled while out-of-frame is low, `out_valid` stays 0.
- R2: In T1 mode (code 0), the bit sampled together with the sync pulse is the framing bit and is never delivered. Slot s, bit position b (0..7) is frame bit 1+8s+b.
- R3: In the E1 modes (code 1, 2 and 3), slot s, bit position b is frame bit 8s+b. The frame lengths are 256, 512 and 1024 bits, and the T1 frame length is 193 bits. Without a new sync pulse, the position wraps to frame bit 0 after the last bit of the frame.
- R4: A slot whose descriptor has enable=1 and whole=1 delivers all 8 of its bits to the slot's channel number. Any set of slots, contiguous or not, may share one channel.
- R5: A slot with enable=1 and whole=0 delivers bit position b only if bit entry {slot,b} has enable=1. The bit is tagged with that bit entry's own channel number.
- R6: A slot whose descriptor has enable=0 delivers none of its bits.
- R7: A bit sampled on a rising edge appears on `out_data` and `out_chan`, with `out_valid` high for one cycle, directly after that edge. Bit position 0 is the first bit received in a slot, which is its most significant bit.
- R8: A bit sampled with `rx_oof` high is not delivered. After `rx_oof` falls, delivery stays off until a sync pulse is sampled with `rx_oof` low; a sync pulse sampled with `rx_oof` high does not restore alignment.
- R9: A sync pulse sampled in the middle of a frame restarts the position at frame bit 0.
- R10: A table write is done by `cfg_sel`=0 with `cfg_addr` = slot for a slot descriptor, or by `cfg_sel`=1 with `cfg_addr` = slot*8+b for a bit entry. It governs every bit sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Frame geometry: 0 T1, 1 E1, 2 double E1, 3 quadruple E1 |
| rx_data | input | 1 | Received serial data bit |
| rx_sync | input | 1 | High on the first bit of a frame |
| rx_oof | input | 1 | Out-of-frame indication from the line side |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 1 | 0 selects the slot table, 1 selects the bit table |
| cfg_addr | input | 10 | Slot number, or slot*8 + bit position |
| cfg_en | input | 1 | Enable of the entry being written |
| cfg_wide | input | 1 | Whole-slot flag (slot table only) |
| cfg_chan | input | 5 | Logical channel of the entry being written |
| out_valid | output | 1 | One-cycle strobe per delivered bit |
| out_data | output | 1 | Delivered data bit |
| out_chan | output | 5 | Logical channel of the delivered bit |

## Verification
Each bit and its delivery decision are due in the cycle right after the rising edge that sampled them. The bench changes inputs only on falling edges and compares the outputs at the following falling edge against the previous bit's expectation. Table writes take effect at the next edge, so the bench loads the table with out-of-frame held high and then starts every run with a sync pulse. The expected channel and enable for every slot and bit come from arithmetic formulas in the bench. Every mode is swept over whole frames, including a wrap without sync, a mid-frame resync and out-of-frame windows.

// File: rtl/chan_rx_pkg.sv
package chan_rx_pkg;

  localparam int SLOT_BITS     = 8;
  localparam int DEF_CHAN_W    = 5;
  localparam int DEF_MAX_SLOTS = 128;

  typedef enum logic [1:0] {
    FR_T1   = 2'd0,
    FR_E1   = 2'd1,
    FR_E1X2 = 2'd2,
    FR_E1X4 = 2'd3
  } frame_mode_e;

  // number of eight-bit slots carried by one frame
  function automatic int slots_in(frame_mode_e m);
    case (m)
      FR_T1:   return 24;
      FR_E1:   return 32;
      FR_E1X2: return 64;
      default: return 128;
    endcase
  endfunction

  // total bits per frame, T1 adds the leading framing bit
  function automatic int frame_len(frame_mode_e m);
    return slots_in(m) * SLOT_BITS + ((m == FR_T1) ? 1 : 0);
  endfunction

endpackage

// File: rtl/chan_rx_framer.sv
module chan_rx_framer
  import chan_rx_pkg::*;
#(
  parameter int POS_W  = 10,
  parameter int SLOT_W = 7,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_mode_e       mode,
  input  logic              rx_sync,
  input  logic              rx_oof,
  output logic              live,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BIT_W-1:0]  bit_idx
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] pos_cur;
  logic [POS_W-1:0] pos_adj;
  logic [POS_W:0]   len;
  logic             in_frame_q;
  logic             in_frame_d;
  logic             is_t1;
  logic             pos_ok;
  logic             framing_bit;

  always_comb begin
    is_t1       = (mode == FR_T1);
    len         = (POS_W+1)'(frame_len(mode));
    // position of the bit being sampled on this edge
    pos_cur     = rx_sync ? '0 : pos_q;
    pos_ok      = ({1'b0, pos_cur} < len);
    framing_bit = is_t1 && (pos_cur == '0);
    if (({1'b0, pos_cur} + (POS_W+1)'(1)) >= len) begin
      pos_d = '0;
    end else begin
      pos_d = pos_cur + POS_W'(1);
    end
    // alignment: lost on out-of-frame, regained by a clean sync
    if (rx_oof) begin
      in_frame_d = 1'b0;
    end else if (rx_sync) begin
      in_frame_d = 1'b1;
    end else begin
      in_frame_d = in_frame_q;
    end
    pos_adj  = pos_cur - POS_W'(is_t1);
    slot_idx = pos_adj[POS_W-1:BIT_W];
    bit_idx  = pos_adj[BIT_W-1:0];
    live     = !rx_oof && (rx_sync || in_frame_q) && pos_ok && !framing_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
    end else begin
      pos_q      <= pos_d;
      in_frame_q <= in_frame_d;
    end
  end

endmodule

// File: rtl/chan_rx_desc.sv
module chan_rx_desc
  import chan_rx_pkg::*;
#(
  parameter int MAX_SLOTS = 128,
  parameter int CHAN_W    = 5,
  parameter int SLOT_W    = 7,
  parameter int BIT_W     = 3,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic              cfg_wide,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [BIT_W-1:0]  rd_bit,
  output logic              rd_hit,
  output logic [CHAN_W-1:0] rd_chan
);

  localparam int NBITS = MAX_SLOTS * SLOT_BITS;

  logic [MAX_SLOTS-1:0] slot_en_v;
  logic [MAX_SLOTS-1:0] slot_wide_v;
  logic [CHAN_W-1:0]    slot_chan_a [MAX_SLOTS];
  logic [NBITS-1:0]     bit_en_v;
  logic [CHAN_W-1:0]    bit_chan_a  [NBITS];

  logic slot_wr_sel;
  logic bit_wr_sel;

  always_comb begin
    slot_wr_sel = cfg_we && !cfg_sel;
    bit_wr_sel  = cfg_we && cfg_sel;
  end

  for (genvar gs = 0; gs < MAX_SLOTS; gs++) begin : g_slot
    logic              wr;
    logic              en_q;
    logic              wide_q;
    logic [CHAN_W-1:0] chan_q;

    assign wr = slot_wr_sel && (cfg_addr[SLOT_W-1:0] == SLOT_W'(gs));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
      end else if (wr) begin
        en_q <= cfg_en;
      end
    end

    always_ff @(posedge clk) begin
      if (wr) begin
        wide_q <= cfg_wide;
        chan_q <= cfg_chan;
      end
    end

    assign slot_en_v[gs]   = en_q;
    assign slot_wide_v[gs] = wide_q;
    assign slot_chan_a[gs] = chan_q;

    for (genvar gb = 0; gb < SLOT_BITS; gb++) begin : g_bit
      localparam int IDX = gs * SLOT_BITS + gb;
      logic              bwr;
      logic              ben_q;
      logic [CHAN_W-1:0] bchan_q;

      assign bwr = bit_wr_sel && (cfg_addr == ADDR_W'(IDX));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ben_q <= 1'b0;
        end else if (bwr) begin
          ben_q <= cfg_en;
        end
      end

      always_ff @(posedge clk) begin
        if (bwr) begin
          bchan_q <= cfg_chan;
        end
      end

      assign bit_en_v[IDX]   = ben_q;
      assign bit_chan_a[IDX] = bchan_q;
    end
  end

  logic [ADDR_W-1:0] rd_addr;
  logic              s_en;
  logic              s_wide;

  always_comb begin
    rd_addr = {rd_slot, rd_bit};
    s_en    = slot_en_v[rd_slot];
    s_wide  = slot_wide_v[rd_slot];
    rd_hit  = s_en && (s_wide || bit_en_v[rd_addr]);
    rd_chan = s_wide ? slot_chan_a[rd_slot] : bit_chan_a[rd_addr];
  end

endmodule

// File: rtl/chan_rx_outreg.sv
module chan_rx_outreg #(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              bit_in,
  input  logic [CHAN_W-1:0] chan_in,
  output logic              out_valid,
  output logic              out_data,
  output logic [CHAN_W-1:0] out_chan
);

  logic              valid_q;
  logic              data_q;
  logic [CHAN_W-1:0] chan_q;
  logic              load_en;

  assign load_en = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= bit_in;
      chan_q <= chan_in;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_chan  = chan_q;

endmodule

// File: rtl/chan_rx_demux.sv
module chan_rx_demux
  import chan_rx_pkg::*;
#(
  parameter int MAX_SLOTS = DEF_MAX_SLOTS,
  parameter int CHAN_W    = DEF_CHAN_W,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int ADDR_W   = SLOT_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              rx_data,
  input  logic              rx_sync,
  input  logic              rx_oof,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic              cfg_wide,
  input  logic [CHAN_W-1:0] cfg_chan,
  output logic              out_valid,
  output logic              out_data,
  output logic [CHAN_W-1:0] out_chan
);

  frame_mode_e       fmode;
  logic              live;
  logic [SLOT_W-1:0] slot_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              desc_hit;
  logic [CHAN_W-1:0] desc_chan;
  logic              deliver;

  assign fmode   = frame_mode_e'(mode);
  assign deliver = live && desc_hit;

  chan_rx_framer #(
    .POS_W  (ADDR_W),
    .SLOT_W (SLOT_W),
    .BIT_W  (BIT_W)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (fmode),
    .rx_sync  (rx_sync),
    .rx_oof   (rx_oof),
    .live     (live),
    .slot_idx (slot_idx),
    .bit_idx  (bit_idx)
  );

  chan_rx_desc #(
    .MAX_SLOTS (MAX_SLOTS),
    .CHAN_W    (CHAN_W),
    .SLOT_W    (SLOT_W),
    .BIT_W     (BIT_W),
    .ADDR_W    (ADDR_W)
  ) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_addr (cfg_addr),
    .cfg_en   (cfg_en),
    .cfg_wide (cfg_wide),
    .cfg_chan (cfg_chan),
    .rd_slot  (slot_idx),
    .rd_bit   (bit_idx),
    .rd_hit   (desc_hit),
    .rd_chan  (desc_chan)
  );

  chan_rx_outreg #(
    .CHAN_W (CHAN_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (deliver),
    .bit_in    (rx_data),
    .chan_in   (desc_chan),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan)
  );

endmodule

// File: rtl/chan_rx_demux_chk.sv
module chan_rx_demux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       rx_data,
  input logic       rx_sync,
  input logic       rx_oof,
  input logic       out_valid,
  input logic       out_data
);

  logic aligned_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
    end else if (rx_oof) begin
      aligned_q <= 1'b0;
    end else if (rx_sync) begin
      aligned_q <= 1'b1;
    end
  end

  // R1
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> aligned_q);

  // R8
  oof_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_oof |=> !out_valid);

  // R2
  t1_frame_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && rx_sync) |=> !out_valid);

  // R7
  data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == $past(rx_data)));

endmodule

bind chan_rx_demux chan_rx_demux_chk u_chk (.*);

// File: tb/tb_chan_rx_demux.sv
`timescale 1ns/1ps
module tb_chan_rx_demux;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       rx_data, rx_sync, rx_oof;
  logic       cfg_we, cfg_sel, cfg_en, cfg_wide;
  logic [9:0] cfg_addr;
  logic [4:0] cfg_chan;
  logic       out_valid, out_data;
  logic [4:0] out_chan;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] lfsr = 16'hACE1;

  chan_rx_demux dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  function automatic int slots_of(int m);
    return (m == 0) ? 24 : (m == 1) ? 32 : (m == 2) ? 64 : 128;
  endfunction
  function automatic int fbits(int m);
    return slots_of(m) * 8 + ((m == 0) ? 1 : 0);
  endfunction
  function automatic bit  s_en(int s, int k);   return ((s + k) % 5) != 3;       endfunction
  function automatic bit  s_wide(int s, int k); return ((s + 2*k) % 3) != 0;     endfunction
  function automatic int  s_chan(int s, int k); return (s*7 + k*11) % 32;        endfunction
  function automatic bit  b_en(int s, int b, int k);  return ((s + b + k) % 3) != 1; endfunction
  function automatic int  b_chan(int s, int b, int k); return (s + 3*b + 5*k) % 32; endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_chan(input string req, input logic [4:0] act, input int exp);
    n_checks++;
    if (act !== 5'(exp)) begin
      n_fail++;
      $display("FAIL %s channel: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R10 load both tables from the formulas with salt k
  task automatic load_tables(input int k);
    @(negedge clk);
    rx_oof = 1'b1; rx_sync = 1'b0;
    for (int s = 0; s < 128; s++) begin
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 10'(s);
      cfg_en = s_en(s, k); cfg_wide = s_wide(s, k); cfg_chan = 5'(s_chan(s, k));
      @(negedge clk);
    end
    for (int a = 0; a < 1024; a++) begin
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 10'(a);
      cfg_en = b_en(a / 8, a % 8, k); cfg_wide = 1'b0; cfg_chan = 5'(b_chan(a / 8, a % 8, k));
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  task automatic run(input int m, input int ncyc, input int first_sync, input int sync_per,
                     input int oof_lo, input int oof_hi, input int k, input string tag);
    bit    aligned = 0;
    int    pos = 0;
    bit    pv = 0;
    bit    pd = 0;
    int    pc = 0;
    string pcat = "";
    mode = 2'(m);
    for (int c = 0; c <= ncyc; c++) begin
      @(negedge clk);
      if (c > 0) begin
        check({pcat, " ", tag, " valid"}, out_valid, pv);
        if (pv && out_valid) begin
          check({"R7 ", tag, " data"}, out_data, pd);
          check_chan({pcat, " ", tag}, out_chan, pc);
        end
      end
      if (c < ncyc) begin
        bit sync = (c >= first_sync) && (((c - first_sync) % sync_per) == 0);
        bit oof  = (c >= oof_lo) && (c < oof_hi);
        bit live;
        int cur, p, s, b;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rx_sync = sync; rx_oof = oof; rx_data = lfsr[0];
        cur  = sync ? 0 : pos;
        live = !oof && (sync || aligned);
        aligned = oof ? 1'b0 : (sync ? 1'b1 : aligned);
        pos  = (cur + 1 >= fbits(m)) ? 0 : cur + 1;
        pd = lfsr[0]; pc = 0; pv = 0;
        if (oof)            pcat = "R8";
        else if (!live)     pcat = "R1";
        else if (m == 0 && cur == 0) pcat = "R2";
        else begin
          p = (m == 0) ? cur - 1 : cur;
          s = p / 8; b = p % 8;
          if (!s_en(s, k)) pcat = "R6";
          else if (s_wide(s, k)) begin pcat = "R4"; pv = 1; pc = s_chan(s, k); end
          else begin pcat = "R5"; pv = b_en(s, b, k); pc = b_chan(s, b, k); end
        end
      end else begin
        rx_sync = 1'b0; rx_oof = 1'b1;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'd1; rx_data = 1'b0; rx_sync = 1'b0; rx_oof = 1'b1;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_addr = '0; cfg_en = 1'b0; cfg_wide = 1'b0; cfg_chan = '0;
    repeat (4) @(negedge clk);
    check("R1 reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", out_valid, 1'b0);
    load_tables(0);
    run(1, 600, 40, 256, 0, 0, 0, "R1 R3 E1");
    run(0, 193*3, 0, 100000, 0, 0, 0, "R2 R3 T1 wrap");
    run(0, 193*2, 0, 193, 0, 0, 0, "R2 T1 sync");
    run(2, 1100, 0, 512, 0, 0, 0, "R3 E1x2");
    run(3, 2100, 0, 1024, 0, 0, 0, "R3 E1x4");
    run(1, 800, 0, 300, 0, 0, 0, "R9 resync");
    run(1, 800, 0, 256, 100, 140, 0, "R8 window");
    run(1, 800, 0, 256, 250, 260, 0, "R8 over sync");
    load_tables(1);
    run(1, 520, 0, 256, 0, 0, 1, "R10 E1");
    run(0, 400, 0, 193, 0, 0, 1, "R10 T1");
    run(3, 1030, 0, 1024, 0, 0, 1, "R10 E1x4");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule